// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block collects up to 32 interrupt sources and presents them to a processor as a single request line. It also offers an eight-word register window that software uses to manage those sources. Each source is fixed at build time as either rising-edge or level triggered. Captured requests collect in a status register. Software masks them through an enable register, which it can write whole or change atomically through separate set and clear ports. It clears captured requests with a write-one-to-clear acknowledge port.

A vector register returns the number of the lowest-numbered pending source, or all ones when nothing is pending. A two-bit master control separately gates the request output and the capture of new hardware events.

Reads are combinational from the word address. A write takes effect on the rising clock edge at which the write strobe is high.

Top module: `vic_top`

## Requirements
- R1: Word offsets decode as follows: 0 status (read only, writes ignored), 1 pending (read only), 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector (read only), 7 master control. Reads of offsets 3, 4 and 5 return 0. Offset 7 reads the two master bits in bits 1:0, with zeros above.
- R2: A write to offset 4 ORs the written mask into the enable register.
- R3: A write to offset 5 clears every enable bit where the mask holds a 1.
- R4: A write to offset 2 replaces the enable register, so writing 0 disables every source. After reset, status, enable and master control are 0, irq_o is low and the vector reads 0xFFFFFFFF.
- R5: A write to offset 3 clears each status bit whose mask bit is 1. Writing 0xFFFFFFFF clears all of them.
- R6: Pending is status AND enable. The vector reads the index of the lowest set pending bit, zero-extended, and reads 0xFFFFFFFF when pending is 0.
- R7: A source whose EDGE_MASK bit is 1 sets its status bit on a rising input. The bit then holds until it is acknowledged, even after the input falls or stays high.
- R8: A source whose EDGE_MASK bit is 0 sets its status bit on every clock edge at which the input is high. Acknowledging it clears the bit only once the input is low.
- R9: irq_o is high exactly when master bit 0 is 1 and pending is non-zero.
- R10: While master bit 1 is 0, no source sets any status bit. Events on the inputs during that time are lost.
- R11: When an acknowledge and a new capture hit the same status bit in the same cycle, the capture wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Interrupt source inputs |
| we_i | input | 1 | Write strobe for the register window |
| addr_i | input | 3 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A software acknowledge and a hardware capture can land on the same status bit at the same clock edge. The bench provokes this in two ways. First, it writes the acknowledge mask in the very cycle an edge source rises. Second, it acknowledges a level source while the source is still held high. In both cases the status read that follows must still show the bit set. A follow-up acknowledge with no new event must then clear it, which shows that the earlier survival came from the capture and not from an acknowledge that failed.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFF_STAT = 3'd0,
    OFF_PEND = 3'd1,
    OFF_EN   = 3'd2,
    OFF_ACK  = 3'd3,
    OFF_SET  = 3'd4,
    OFF_CLR  = 3'd5,
    OFF_VEC  = 3'd6,
    OFF_MER  = 3'd7
  } reg_off_e;
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int          N_SRC     = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             cap_en_i,
  input  logic             ack_v_i,
  input  logic [N_SRC-1:0] ack_mask_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] prev_q, hw_set, status_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      assign hw_set[i] = cap_en_i & src_i[i] & ~prev_q[i];
    end else begin : g_level
      assign hw_set[i] = cap_en_i & src_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= src_i;
      // capture has priority over acknowledge
      status_q <= (status_q & ~(ack_v_i ? ack_mask_i : '0)) | hw_set;
    end
  end

  assign status_o = status_q;

  // R5
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_v_i |=> ((status_o & $past(ack_mask_i & ~hw_set)) == '0));

  // R10
  no_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> ((status_o & ~$past(status_o)) == '0));

  // R11
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set != '0) |=> ((status_o & $past(hw_set)) == $past(hw_set)));

  // R7
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_v_i |=> (($past(status_o) & ~status_o) == '0));
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N_SRC = 32,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int          N_SRC     = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  reg_off_e         off;
  logic [N_SRC-1:0] wmask, en_q, status, pend;
  logic [1:0]       mer_q;
  logic             ack_v, vec_any;
  logic [IDX_W-1:0] vec_idx;

  assign off   = reg_off_e'(addr_i);
  assign wmask = wdata_i[N_SRC-1:0];
  assign ack_v = we_i && (off == OFF_ACK);

  vic_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .cap_en_i   (mer_q[1]),
    .ack_v_i    (ack_v),
    .ack_mask_i (wmask),
    .status_o   (status)
  );

  assign pend = status & en_q;

  vic_prio #(.N_SRC(N_SRC)) u_prio (
    .pend_i (pend),
    .any_o  (vec_any),
    .idx_o  (vec_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      mer_q <= '0;
    end else if (we_i) begin
      unique case (off)
        OFF_EN:  en_q  <= wmask;
        OFF_SET: en_q  <= en_q | wmask;
        OFF_CLR: en_q  <= en_q & ~wmask;
        OFF_MER: mer_q <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (off)
      OFF_STAT: rdata_o = REG_W'(status);
      OFF_PEND: rdata_o = REG_W'(pend);
      OFF_EN:   rdata_o = REG_W'(en_q);
      OFF_VEC:  rdata_o = vec_any ? REG_W'(vec_idx) : '1;
      OFF_MER:  rdata_o = REG_W'(mer_q);
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = mer_q[0] & vec_any;

  // R2
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && off == OFF_SET) |=> ((en_q & $past(wmask)) == $past(wmask)));

  // R3
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && off == OFF_CLR) |=> ((en_q & $past(wmask)) == '0));

  // R6
  vec_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_any |-> (pend[vec_idx] &&
      ((pend & ((N_SRC'(1) << vec_idx) - N_SRC'(1))) == '0)));

  // R6
  vec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_any |-> ((status & en_q) == '0));

  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mer_q[0] && pend != '0));
endmodule

// File: tb/tb_vic_top.sv
`timescale 1ns/1ps
module tb_vic_top;
  localparam int          N  = 32;
  localparam logic [31:0] EM = 32'h0000_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  vic_top #(.N_SRC(N), .EDGE_MASK(EM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compare as soon as an expectation appears
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (q.size() != 0);
      it = q.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = 3'(a);
    we   = 1'b0;
    #2;
    q.push_back('{1'b0, e, tag});
  endtask

  task automatic chk_irq(input bit e, input string tag);
    @(negedge clk);
    #2;
    q.push_back('{1'b1, {31'b0, e}, tag});
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 3'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); src[i] = 1'b1;
    @(negedge clk); src[i] = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 reset state
    rd(0, 32'h0, "R4 status after reset");
    rd(2, 32'h0, "R4 enable after reset");
    rd(7, 32'h0, "R4 master after reset");
    rd(6, 32'hFFFF_FFFF, "R4 vector after reset");
    chk_irq(0, "R4 irq after reset");

    wr(7, 32'hFFFF_FFFF);
    rd(7, 32'h3, "R1 master readback");
    wr(4, 32'h5);
    rd(2, 32'h5, "R2 set enable");
    wr(4, 32'h1_0000);
    rd(2, 32'h1_0005, "R2 set ORs");
    wr(5, 32'h4);
    rd(2, 32'h1_0001, "R3 clear enable");
    rd(3, 32'h0, "R1 ack reads 0");
    rd(4, 32'h0, "R1 set reads 0");
    rd(5, 32'h0, "R1 clr reads 0");

    pulse(3);
    rd(0, 32'h8, "R7 edge latched and held");
    rd(1, 32'h0, "R6 pending masked");
    rd(6, 32'hFFFF_FFFF, "R6 vector idle");
    chk_irq(0, "R9 no pending no irq");
    wr(4, 32'h8);
    rd(1, 32'h8, "R6 pending after enable");
    rd(6, 32'd3, "R6 vector 3");
    chk_irq(1, "R9 irq asserted");

    pulse(1);
    rd(6, 32'd3, "R6 src1 not enabled");
    wr(4, 32'h2);
    rd(6, 32'd1, "R6 lowest wins");
    wr(3, 32'h2);
    rd(0, 32'h8, "R5 ack clears bit1");
    rd(6, 32'd3, "R5 vector after ack");

    wr(7, 32'h2);
    chk_irq(0, "R9 master bit0 off");
    rd(6, 32'd3, "R9 vector unaffected");
    wr(7, 32'h3);
    chk_irq(1, "R9 master bit0 on");

    @(negedge clk); src[16] = 1'b1;
    rd(0, 32'h1_0008, "R8 level sets");
    wr(3, 32'h1_0000);
    rd(0, 32'h1_0008, "R8 ack while high keeps bit");
    @(negedge clk); src[16] = 1'b0;
    wr(3, 32'h1_0000);
    rd(0, 32'h8, "R8 ack after low clears");

    wr(7, 32'h1);
    pulse(5);
    rd(0, 32'h8, "R10 edge ignored");
    @(negedge clk); src[20] = 1'b1;
    rd(0, 32'h8, "R10 level ignored");
    @(negedge clk); src[20] = 1'b0;
    chk_irq(1, "R10 irq still from old bit");
    wr(7, 32'h3);
    rd(0, 32'h8, "R10 lost events stay lost");

    // R11 ack of bit3 in the cycle src3 rises
    @(negedge clk);
    addr = 3'd3; wdata = 32'h8; we = 1'b1; src[3] = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd(0, 32'h8, "R11 capture beats ack");
    wr(3, 32'h8);
    rd(0, 32'h0, "R7 held-high edge source acked");
    @(negedge clk); src[3] = 1'b0;

    pulse(0); pulse(2);
    rd(6, 32'd0, "R6 vector 0");
    wr(3, 32'hFFFF_FFFF);
    rd(0, 32'h0, "R5 ack all");
    rd(6, 32'hFFFF_FFFF, "R5 vector idle after ack all");
    chk_irq(0, "R5 irq low after ack all");

    wr(2, 32'hFFFF_FFFF);
    rd(2, 32'hFFFF_FFFF, "R4 direct enable write");
    wr(2, 32'h0);
    rd(2, 32'h0, "R4 enable write zero");
    pulse(4);
    wr(0, 32'h0);
    rd(0, 32'h10, "R1 status write ignored");
    wr(6, 32'h0);
    rd(6, 32'hFFFF_FFFF, "R1 vector write ignored");

    wait (q.size() == 0);
    #5;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule